// File: doc/BRIEF.md
# Lane Receive FIFO with Type-Filtered Writes

This block sits at the receive end of one serial lane carrying a 64b/67b-style framed stream. Every incoming word carries a 64-bit payload, a flag that marks it as a control word, and a flag that marks it as a framing sync word. A framing tracker looks for sync words at a fixed metaframe spacing, declares frame lock, and drops lock when that spacing breaks down. A filter in front of the storage decides, word by word, whether the word is kept. The decision depends on two runtime switches, one for control-word removal and one for sync-word removal, and on the lock state.

The write side has no back-pressure. The line cannot be stalled, so there is no ready signal on the input. A word that the filter keeps while the storage is full is lost and sets a sticky overflow flag. The read side is a pop interface. When `rd_en` is high on a cycle where the FIFO holds data, one word is removed. That word appears on `rd_word` one cycle later, with `rd_valid` high on that cycle only. A pop request on an empty FIFO is ignored. The status flags come straight from the stored word count, and the consumer uses them to pace its pops.

Top module: `lane_rx_filter_fifo`

## Requirements
- R1: After reset the FIFO is empty: `fifo_empty`=1, `fifo_pempty`=1, `fifo_full`=0, `fifo_pfull`=0, `rd_valid`=0, `overflow`=0, `frame_locked`=0, `align_found`=0.
- R2: With `ctl_del_en`=0, every valid input word is stored in arrival order, whatever its type: data, control or sync.
- R3: With `ctl_del_en`=1, a valid word with `in_ctrl`=1 and `in_sync`=0 is discarded. Data words are still stored.
- R4: With `ctl_del_en`=1 and `sync_del_en`=1, every sync word is discarded while frame lock holds. This includes the sync word that completes lock. Sync words that arrive before lock are stored.
- R5: `sync_del_en` has no effect while `ctl_del_en`=0. In that case sync words are stored even while locked.
- R6: `frame_locked` rises on the edge that accepts the 4th consecutive sync word at the metaframe spacing (`METAFRAME`=2048 valid words from one sync to the next). It falls on the edge that accepts the 4th consecutive mismatch. A mismatch is either a non-sync word in the expected slot or a sync word outside that slot.
- R7: `align_found` is high for exactly the one cycle after a valid sync word is accepted at the input.
- R8: When `rd_en` is high and the FIFO is not empty, exactly one word is popped. It is the oldest word, and it is presented on `rd_word` with `rd_valid`=1 in the following cycle.
- R9: When `rd_en` is high and the FIFO is empty, nothing is popped, and `rd_valid` is 0 in the following cycle.
- R10: The flags follow the stored count N, with depth 32: `fifo_full` = (N==32), `fifo_pfull` = (N>=24), `fifo_empty` = (N==0), `fifo_pempty` = (N<=8).
- R11: A kept word that arrives while the FIFO is full is dropped. `overflow` then goes to 1 and stays at 1 until reset.
- R12: The stored word layout is: bits [63:0] payload, bit [64] control flag, bit [65] sync flag, bit [66] reserved and always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present this cycle (no ready) |
| in_data | input | 64 | Input payload |
| in_ctrl | input | 1 | Input word is a control word |
| in_sync | input | 1 | Input word is a framing sync word |
| ctl_del_en | input | 1 | Discard non-sync control words |
| sync_del_en | input | 1 | Discard sync words while locked (needs ctl_del_en) |
| rd_en | input | 1 | Pop one word |
| rd_word | output | 67 | Popped word, layout per R12 |
| rd_valid | output | 1 | rd_word holds a popped word |
| align_found | output | 1 | Pulse: sync word seen on the previous cycle |
| frame_locked | output | 1 | Framing lock state |
| fifo_full | output | 1 | Count equals depth |
| fifo_pfull | output | 1 | Count at or above the upper threshold |
| fifo_empty | output | 1 | Count is zero |
| fifo_pempty | output | 1 | Count at or below the lower threshold |
| overflow | output | 1 | Sticky: a kept word was lost to a full FIFO |

## Verification
The filter is tried first with single unlocked words covering every combination of word type and the two deletion switches. Each word is either popped back and compared field by field, or shown to be absent through `fifo_empty`. This separates control removal from sync removal, and separates each of them from plain storage. A long stream then places sync words at the 2048-word spacing between discarded control fillers. This shows that the lock-completing sync is itself removed, that later syncs are removed only while both switches are on, and that lock survives three missed slots but not four. A final fill of 33 numbered data words, followed by a full drain, walks each flag across its threshold, shows the overflow drop, and confirms arrival order.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
  localparam int DATA_W = 64;
  localparam int WORD_W = DATA_W + 3;

  typedef struct packed {
    logic              rsvd;
    logic              sync;
    logic              ctrl;
    logic [DATA_W-1:0] data;
  } lrf_word_t;
endpackage

// File: rtl/lrf_frame_lock.sv
module lrf_frame_lock #(
  parameter int METAFRAME = 2048,
  parameter int LOCK_CNT  = 4,
  parameter int LOSS_CNT  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic sync,
  output logic locked,
  output logic lock_eff,
  output logic align_found
);
  localparam int PW     = $clog2(METAFRAME);
  localparam int CNTMAX = (LOCK_CNT > LOSS_CNT) ? LOCK_CNT : LOSS_CNT;
  localparam int CW     = $clog2(CNTMAX + 1);

  logic [PW-1:0] pos_q;
  logic [CW-1:0] good_q, bad_q;
  logic          locked_q, align_q;
  logic          at_slot, completing;

  assign at_slot    = (pos_q == PW'(METAFRAME - 1));
  assign completing = vld && sync && !locked_q && (good_q != '0) && at_slot &&
                      (good_q == CW'(LOCK_CNT - 1));
  assign lock_eff    = locked_q || completing;
  assign locked      = locked_q;
  assign align_found = align_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q    <= '0;
      good_q   <= '0;
      bad_q    <= '0;
      locked_q <= 1'b0;
      align_q  <= 1'b0;
    end else begin
      align_q <= vld && sync;
      if (vld) begin
        if (!locked_q) begin
          if (sync && ((good_q == '0) || !at_slot)) begin
            good_q <= CW'(1);
            pos_q  <= '0;
          end else if ((good_q != '0) && at_slot) begin
            pos_q <= '0;
            if (sync) begin
              if (good_q == CW'(LOCK_CNT - 1)) begin
                locked_q <= 1'b1;
                good_q   <= '0;
                bad_q    <= '0;
              end else begin
                good_q <= good_q + CW'(1);
              end
            end else begin
              good_q <= '0;
            end
          end else begin
            pos_q <= pos_q + PW'(1);
          end
        end else begin
          if (at_slot) pos_q <= '0;
          else         pos_q <= pos_q + PW'(1);
          if (at_slot && sync) begin
            bad_q <= '0;
          end else if (at_slot || sync) begin
            if (bad_q == CW'(LOSS_CNT - 1)) begin
              locked_q <= 1'b0;
              bad_q    <= '0;
            end else begin
              bad_q <= bad_q + CW'(1);
            end
          end
        end
      end
    end
  end

  // R6
  lock_rise_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(vld && sync));

  // R6
  lock_fall_on_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_q) |-> $past(vld));

  // R7
  align_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && sync) |=> align_found);
endmodule

// File: rtl/lrf_word_filter.sv
module lrf_word_filter
  import lrf_pkg::*;
(
  input  logic              vld,
  input  logic [DATA_W-1:0] data,
  input  logic              ctrl,
  input  logic              sync,
  input  logic              ctl_del,
  input  logic              sync_del,
  input  logic              lock_eff,
  output logic              keep,
  output lrf_word_t         word
);
  logic drop_sync, drop_ctrl;

  // sync removal only counts when control removal is on as well
  assign drop_sync = sync && ctl_del && sync_del && lock_eff;
  assign drop_ctrl = !sync && ctrl && ctl_del;
  assign keep      = vld && !drop_sync && !drop_ctrl;

  always_comb begin
    word.rsvd = 1'b0;
    word.sync = sync;
    word.ctrl = ctrl;
    word.data = data;
  end

  // R5
  always_comb begin
    if (vld && sync && !ctl_del) sync_kept_without_ctl_del_chk: assert (keep);
  end
endmodule

// File: rtl/lrf_fifo.sv
module lrf_fifo #(
  parameter int DEPTH  = 32,
  parameter int PFULL  = 24,
  parameter int PEMPTY = 8,
  parameter int W      = 67
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_word,
  input  logic         rd_en,
  output logic [W-1:0] rd_word,
  output logic         rd_valid,
  output logic         full,
  output logic         pfull,
  output logic         empty,
  output logic         pempty,
  output logic         overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign full   = (cnt_q == CW'(DEPTH));
  assign pfull  = (cnt_q >= CW'(PFULL));
  assign empty  = (cnt_q == '0);
  assign pempty = (cnt_q <= CW'(PEMPTY));
  assign do_wr  = wr_en && !full;
  assign do_rd  = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q     <= '0;
      rp_q     <= '0;
      cnt_q    <= '0;
      rd_valid <= 1'b0;
      rd_word  <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_wr) wp_q <= wp_q + AW'(1);
      if (do_rd) begin
        rp_q    <= rp_q + AW'(1);
        rd_word <= mem[rp_q];
      end
      cnt_q    <= cnt_q + CW'(do_wr) - CW'(do_rd);
      rd_valid <= do_rd;
      overflow <= overflow | (wr_en && full);
    end
  end

  // R8
  pop_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty) |=> rd_valid);

  // R9
  empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> !rd_valid);

  // R11
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R10
  flag_nesting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full |-> pfull) and (empty |-> pempty) and !(full && empty));
endmodule

// File: rtl/lane_rx_filter_fifo.sv
module lane_rx_filter_fifo
  import lrf_pkg::*;
#(
  parameter int METAFRAME = 2048,
  parameter int LOCK_CNT  = 4,
  parameter int LOSS_CNT  = 4,
  parameter int DEPTH     = 32,
  parameter int PFULL     = 24,
  parameter int PEMPTY    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_ctrl,
  input  logic              in_sync,
  input  logic              ctl_del_en,
  input  logic              sync_del_en,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_valid,
  output logic              align_found,
  output logic              frame_locked,
  output logic              fifo_full,
  output logic              fifo_pfull,
  output logic              fifo_empty,
  output logic              fifo_pempty,
  output logic              overflow
);
  logic      lock_eff, keep;
  lrf_word_t word;

  lrf_frame_lock #(
    .METAFRAME(METAFRAME), .LOCK_CNT(LOCK_CNT), .LOSS_CNT(LOSS_CNT)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .vld(in_valid), .sync(in_sync),
    .locked(frame_locked), .lock_eff(lock_eff), .align_found(align_found)
  );

  lrf_word_filter u_filt (
    .vld(in_valid), .data(in_data), .ctrl(in_ctrl), .sync(in_sync),
    .ctl_del(ctl_del_en), .sync_del(sync_del_en), .lock_eff(lock_eff),
    .keep(keep), .word(word)
  );

  lrf_fifo #(
    .DEPTH(DEPTH), .PFULL(PFULL), .PEMPTY(PEMPTY), .W(WORD_W)
  ) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(keep), .wr_word(word), .rd_en(rd_en),
    .rd_word(rd_word), .rd_valid(rd_valid), .full(fifo_full), .pfull(fifo_pfull),
    .empty(fifo_empty), .pempty(fifo_pempty), .overflow(overflow)
  );

  // R12
  reserved_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_word[WORD_W-1] == 1'b0));
endmodule

// File: tb/test_lane_rx_filter_fifo.sv
module test_lane_rx_filter_fifo;
  localparam int M = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_ctrl = 1'b0, in_sync = 1'b0;
  logic        ctl_del_en = 1'b0, sync_del_en = 1'b0, rd_en = 1'b0;
  logic [66:0] rd_word;
  logic        rd_valid, align_found, frame_locked;
  logic        fifo_full, fifo_pfull, fifo_empty, fifo_pempty, overflow;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_rx_filter_fifo i_lane_rx_filter_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ctrl(in_ctrl), .in_sync(in_sync), .ctl_del_en(ctl_del_en),
    .sync_del_en(sync_del_en), .rd_en(rd_en), .rd_word(rd_word),
    .rd_valid(rd_valid), .align_found(align_found), .frame_locked(frame_locked),
    .fifo_full(fifo_full), .fifo_pfull(fifo_pfull), .fifo_empty(fifo_empty),
    .fifo_pempty(fifo_pempty), .overflow(overflow)
  );

  // data[68:5] | ctrl[4] | sync[3] | ctl_del[2] | sync_del[1] | stored[0]
  localparam logic [68:0] VEC [8] = '{
    {64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {64'h0000_0000_C0DE_0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {64'h5555_0000_0000_AAAA, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {64'h0000_0000_C0DE_0002, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {64'hFEED_FACE_0000_0003, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {64'h5555_0000_0000_BBBB, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {64'h0000_0000_C0DE_0004, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {64'h5555_0000_0000_CCCC, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] d, input logic c, input logic s,
                      input logic cd, input logic sd);
    in_valid = 1'b1; in_data = d; in_ctrl = c; in_sync = s;
    ctl_del_en = cd; sync_del_en = sd;
    @(posedge clk); #1;
    in_valid = 1'b0; in_ctrl = 1'b0; in_sync = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic fillers(input int n);
    for (int k = 0; k < n; k++) send(64'hF111, 1'b1, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic sync_word(input logic [63:0] d, input logic cd, input logic sd);
    send(d, 1'b1, 1'b1, cd, sd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 flags", {fifo_empty, fifo_pempty, fifo_full, fifo_pfull}, 4'b1100);
    chk("R1 outputs", {rd_valid, overflow, frame_locked, align_found}, 4'b0000);

    // table walk: one word in, then read back or prove absent
    for (int i = 0; i < 8; i++) begin
      send(VEC[i][68:5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      chk("R7 align_found", align_found, VEC[i][3]);
      if (VEC[i][0]) begin
        pop();
        chk("R2/R3/R5 stored word R12", {rd_valid, rd_word},
            {1'b1, 1'b0, VEC[i][3], VEC[i][4], VEC[i][68:5]});
      end else begin
        chk("R3 dropped", fifo_empty, 1'b1);
      end
    end
    pop();
    chk("R9 empty pop", {rd_valid, fifo_empty}, 2'b01);

    // lock acquisition: syncs at metaframe spacing, fillers discarded
    sync_word(64'hA1, 1'b1, 1'b1); fillers(M - 1);
    sync_word(64'hA2, 1'b1, 1'b1); fillers(M - 1);
    sync_word(64'hA3, 1'b1, 1'b1);
    chk("R6 not locked after 3", frame_locked, 1'b0);
    fillers(M - 1);
    sync_word(64'hA4, 1'b1, 1'b1);
    chk("R6 locked after 4", frame_locked, 1'b1);
    for (int k = 1; k <= 3; k++) begin
      pop();
      chk("R4 pre-lock sync kept", rd_word[63:0], 64'hA0 + 64'(k));
    end
    chk("R4 completing sync dropped", fifo_empty, 1'b1);

    fillers(M - 1);
    sync_word(64'hA5, 1'b1, 1'b1);
    chk("R4 locked sync dropped", {fifo_empty, frame_locked}, 2'b11);

    fillers(M - 1);
    sync_word(64'hA6, 1'b0, 1'b1);
    chk("R5 sync kept, ctl_del off", {fifo_empty, frame_locked}, 2'b01);
    pop();
    chk("R5 word", {rd_valid, rd_word}, {1'b1, 3'b011, 64'hA6});

    // lock loss: missing syncs in expected slots
    fillers(3 * M);
    chk("R6 locked after 3 misses", frame_locked, 1'b1);
    fillers(M);
    chk("R6 unlocked after 4 misses", frame_locked, 1'b0);
    chk("R3 fillers dropped", fifo_empty, 1'b1);

    // fill past depth
    for (int n = 1; n <= 33; n++) begin
      send(64'(n), 1'b0, 1'b0, 1'b0, 1'b0);
      if (n == 8)  chk("R10 n=8",  {fifo_empty, fifo_pempty, fifo_pfull, fifo_full}, 4'b0100);
      if (n == 9)  chk("R10 n=9",  {fifo_empty, fifo_pempty, fifo_pfull, fifo_full}, 4'b0000);
      if (n == 23) chk("R10 n=23", {fifo_pfull, fifo_full}, 2'b00);
      if (n == 24) chk("R10 n=24", {fifo_pfull, fifo_full}, 2'b10);
      if (n == 31) chk("R10 n=31", {fifo_pfull, fifo_full, overflow}, 3'b100);
      if (n == 32) chk("R10 n=32", {fifo_pfull, fifo_full, overflow}, 3'b110);
      if (n == 33) chk("R11 overflow", {fifo_full, overflow}, 2'b11);
    end
    for (int n = 1; n <= 32; n++) begin
      pop();
      chk("R8 order", {rd_valid, rd_word}, {1'b1, 3'b000, 64'(n)});
    end
    chk("R10 drained", {fifo_empty, fifo_pempty}, 2'b11);
    pop();
    chk("R9 empty pop after drain", rd_valid, 1'b0);
    chk("R11 overflow sticky", overflow, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule